// File: doc/BRIEF.md
# Dual-Protocol Processor Slave Port

This block lets a peripheral sit on either of two classic 8-bit processor buses. One kind of bus uses separate active-low read and write strobes. The other uses a high-active enable clock together with a read/write direction level. A static mode input selects the kind. The block sees chip select, one address line and the two strobe pins. From them it decodes one of four transfer kinds: a status read, a data read, a parameter/data write or a command write.

Write transfers are brought into the system clock domain through a two-flop synchroniser. The written byte is held in a register with a tag that marks it as a command or as a parameter/data byte. When the transfer ends, the block sends a one-cycle valid pulse to downstream logic. Read transfers drive the data bus straight from the pins, through a separate output and output-enable pair. A0 low returns a status byte and A0 high returns a read-data byte. After each completed data read, a one-cycle acknowledge tells upstream logic to advance its read pointer. The mode input may change only while the bus is idle. Every strobe must stay asserted for at least three clock cycles, with the data held steady until the strobe is released.

Top module: `hostbus_if`

## Requirements
- R1: `mode_sel`=0 selects strobe mode: `rd_e` is the active-low read strobe and `wr_rw` the active-low write strobe. `mode_sel`=1 selects enable mode: `rd_e` is a high-active enable and `wr_rw` is the direction level (1 read, 0 write).
- R2: In strobe mode, with `cs_n`=0, `rd_e`=0 and `wr_rw`=1, the cycle is a read: a status read when `a0`=0 and a data read when `a0`=1.
- R3: In strobe mode, with `cs_n`=0, `rd_e`=1 and `wr_rw`=0, the cycle is a write: parameter/data when `a0`=0 and command when `a0`=1. The byte is taken when `wr_rw` returns high.
- R4: In enable mode, with `cs_n`=0 and `rd_e`=1, `wr_rw`=1 gives a read (status when `a0`=0, data when `a0`=1). `wr_rw`=0 gives a write (parameter/data when `a0`=0, command when `a0`=1). The write completes when `rd_e` falls.
- R5: `bus_oe` is 1 exactly while a read is decoded from the live pins. During a status read `bus_out` equals `status_in`, and during a data read it equals `rdata_in`.
- R6: While `cs_n`=1, `bus_oe` stays 0 and no `wr_valid` or `rd_ack` pulse is produced, whatever the strobes do.
- R7: A completed write produces exactly one single-cycle `wr_valid` pulse. The pulse is seen after the third rising clock edge that follows the end of the strobe. With it, `wr_byte` holds the byte on `bus_in`, `wr_is_cmd`=1 for a command write and `wr_is_cmd`=0 for a parameter/data write.
- R8: A completed data read produces exactly one single-cycle `rd_ack` pulse, with the same latency as R7. A status read produces none.
- R9: While `rst_n`=0, `bus_oe`, `wr_valid`, `rd_ack`, `wr_is_cmd` and `wr_byte` are all 0, even if a read is being signalled on the pins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_sel | input | 1 | Bus protocol select (0 strobe mode, 1 enable mode) |
| cs_n | input | 1 | Active-low chip select |
| a0 | input | 1 | Transfer kind address bit |
| rd_e | input | 1 | Read strobe (mode 0) or enable (mode 1) |
| wr_rw | input | 1 | Write strobe (mode 0) or read/write level (mode 1) |
| bus_in | input | 8 | Data bus as driven by the processor |
| bus_out | output | 8 | Data the block drives on reads |
| bus_oe | output | 1 | Output enable for the data bus drivers |
| status_in | input | 8 | Status byte returned on status reads |
| rdata_in | input | 8 | Byte returned on data reads |
| wr_valid | output | 1 | One-cycle pulse for a completed write |
| wr_is_cmd | output | 1 | Tag: 1 command byte, 0 parameter/data byte |
| wr_byte | output | 8 | Written byte |
| rd_ack | output | 1 | One-cycle pulse for a completed data read |

## Verification
In strobe mode a processor can release the write strobe and assert the read strobe on the same clock. The delayed write pulse from the synchronised path then lands while the live-pin read path is already driving the bus. The bench provokes this by swapping the strobes on one falling edge, with chip select held low. In every cycle of the window it checks that `bus_oe` stays high with `rdata_in` on `bus_out`. It also checks that one `wr_valid` pulse arrives at the third edge with the command byte, and that the following read later ends in a single `rd_ack`.

// File: rtl/hb_pkg.sv
package hb_pkg;

    typedef enum logic [2:0] {
        ACC_IDLE     = 3'd0,
        ACC_STAT_RD  = 3'd1,
        ACC_DATA_RD  = 3'd2,
        ACC_PARAM_WR = 3'd3,
        ACC_CMD_WR   = 3'd4
    } acc_e;

    function automatic logic acc_is_wr(input acc_e a);
        return (a == ACC_PARAM_WR) || (a == ACC_CMD_WR);
    endfunction

    function automatic logic acc_is_rd(input acc_e a);
        return (a == ACC_STAT_RD) || (a == ACC_DATA_RD);
    endfunction

endpackage

// File: rtl/hb_sync.sv
module hb_sync #(
    parameter int            W       = 12,
    parameter int            STAGES  = 2,
    parameter logic [W-1:0]  RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    for (genvar g = 0; g < STAGES; g++) begin : g_stage
        logic [W-1:0] r_q;
        logic [W-1:0] r_d;
        if (g == 0) begin : g_first
            assign r_d = d;
        end else begin : g_next
            assign r_d = g_stage[g-1].r_q;
        end
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) r_q <= RST_VAL;
            else        r_q <= r_d;
        end
    end

    assign q = g_stage[STAGES-1].r_q;

endmodule

// File: rtl/hb_decode.sv
module hb_decode
    import hb_pkg::*;
(
    input  logic mode_sel,
    input  logic cs_n,
    input  logic a0,
    input  logic stb_a,
    input  logic stb_b,
    output acc_e acc
);

    always_comb begin
        acc = ACC_IDLE;
        if (!cs_n) begin
            if (!mode_sel) begin
                // strobe mode: stb_a = read strobe (low), stb_b = write strobe (low)
                if (!stb_a && stb_b)      acc = a0 ? ACC_DATA_RD : ACC_STAT_RD;
                else if (stb_a && !stb_b) acc = a0 ? ACC_CMD_WR  : ACC_PARAM_WR;
            end else begin
                // enable mode: stb_a = enable (high), stb_b = direction (1 read)
                if (stb_a) begin
                    if (stb_b) acc = a0 ? ACC_DATA_RD : ACC_STAT_RD;
                    else       acc = a0 ? ACC_CMD_WR  : ACC_PARAM_WR;
                end
            end
        end
    end

endmodule

// File: rtl/hb_rddrv.sv
module hb_rddrv
    import hb_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              rst_n,
    input  acc_e              acc,
    input  logic [DATA_W-1:0] status_in,
    input  logic [DATA_W-1:0] rdata_in,
    output logic              oe,
    output logic [DATA_W-1:0] dout
);

    always_comb begin
        oe   = rst_n && acc_is_rd(acc);
        dout = '0;
        if (acc == ACC_STAT_RD)      dout = status_in;
        else if (acc == ACC_DATA_RD) dout = rdata_in;
    end

endmodule

// File: rtl/hostbus_if.sv
module hostbus_if
    import hb_pkg::*;
#(
    parameter int DATA_W      = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mode_sel,
    input  logic              cs_n,
    input  logic              a0,
    input  logic              rd_e,
    input  logic              wr_rw,
    input  logic [DATA_W-1:0] bus_in,
    output logic [DATA_W-1:0] bus_out,
    output logic              bus_oe,
    input  logic [DATA_W-1:0] status_in,
    input  logic [DATA_W-1:0] rdata_in,
    output logic              wr_valid,
    output logic              wr_is_cmd,
    output logic [DATA_W-1:0] wr_byte,
    output logic              rd_ack
);

    localparam int PIN_W = DATA_W + 4;
    localparam logic [PIN_W-1:0] PIN_IDLE = {1'b1, {(PIN_W-1){1'b0}}};

    typedef struct packed {
        acc_e              act;
        logic [DATA_W-1:0] hold;
        logic              hold_cmd;
        logic              wr_pulse;
        logic              rd_pulse;
    } state_t;

    logic [PIN_W-1:0] pins_raw, pins_s;
    acc_e             acc_raw, acc_sync;
    state_t           st_d, st_q;

    assign pins_raw = {cs_n, a0, rd_e, wr_rw, bus_in};

    hb_sync #(.W(PIN_W), .STAGES(SYNC_STAGES), .RST_VAL(PIN_IDLE)) sync_i (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (pins_raw),
        .q     (pins_s)
    );

    hb_decode dec_raw_i (
        .mode_sel (mode_sel),
        .cs_n     (cs_n),
        .a0       (a0),
        .stb_a    (rd_e),
        .stb_b    (wr_rw),
        .acc      (acc_raw)
    );

    hb_decode dec_sync_i (
        .mode_sel (mode_sel),
        .cs_n     (pins_s[PIN_W-1]),
        .a0       (pins_s[PIN_W-2]),
        .stb_a    (pins_s[PIN_W-3]),
        .stb_b    (pins_s[PIN_W-4]),
        .acc      (acc_sync)
    );

    hb_rddrv #(.DATA_W(DATA_W)) rddrv_i (
        .rst_n     (rst_n),
        .acc       (acc_raw),
        .status_in (status_in),
        .rdata_in  (rdata_in),
        .oe        (bus_oe),
        .dout      (bus_out)
    );

    always_comb begin
        st_d          = st_q;
        st_d.act      = acc_sync;
        st_d.wr_pulse = acc_is_wr(st_q.act) && (acc_sync != st_q.act);
        st_d.rd_pulse = (st_q.act == ACC_DATA_RD) && (acc_sync != ACC_DATA_RD);
        if (acc_is_wr(acc_sync) && !st_d.wr_pulse) begin
            st_d.hold     = pins_s[DATA_W-1:0];
            st_d.hold_cmd = (acc_sync == ACC_CMD_WR);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.act      <= ACC_IDLE;
            st_q.hold     <= '0;
            st_q.hold_cmd <= 1'b0;
            st_q.wr_pulse <= 1'b0;
            st_q.rd_pulse <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign wr_valid  = st_q.wr_pulse;
    assign rd_ack    = st_q.rd_pulse;
    assign wr_is_cmd = st_q.hold_cmd;
    assign wr_byte   = st_q.hold;

    // R7
    wr_one_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_valid |=> !wr_valid);

    // R7
    wr_after_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_valid |-> $past(acc_is_wr(acc_sync), 2));

    // R7
    wr_byte_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_valid |-> $stable(wr_byte));

    // R8
    rd_ack_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_ack |-> $past(acc_sync == ACC_DATA_RD, 2));

    // R6
    no_drive_deselected_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n |-> !bus_oe);

    // R8
    no_dual_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_valid && rd_ack));

endmodule

// File: tb/hostbus_if_tb_top.sv
module hostbus_if_tb_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       mode_sel = 1'b0;
    logic       cs_n = 1'b1;
    logic       a0 = 1'b0;
    logic       rd_e = 1'b1;
    logic       wr_rw = 1'b1;
    logic [7:0] bus_in = '0;
    logic [7:0] bus_out;
    logic       bus_oe;
    logic [7:0] status_in = 8'h00;
    logic [7:0] rdata_in = 8'h00;
    logic       wr_valid;
    logic       wr_is_cmd;
    logic [7:0] wr_byte;
    logic       rd_ack;

    int n_chk = 0;
    int n_err = 0;

    always #10 clk = ~clk;

    hostbus_if dut_i (
        .clk(clk), .rst_n(rst_n), .mode_sel(mode_sel), .cs_n(cs_n), .a0(a0),
        .rd_e(rd_e), .wr_rw(wr_rw), .bus_in(bus_in), .bus_out(bus_out),
        .bus_oe(bus_oe), .status_in(status_in), .rdata_in(rdata_in),
        .wr_valid(wr_valid), .wr_is_cmd(wr_is_cmd), .wr_byte(wr_byte),
        .rd_ack(rd_ack)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // idle strobe levels for a mode (R1)
    function automatic logic [1:0] idle_stb(input bit m);
        return m ? 2'b01 : 2'b11;
    endfunction

    // active strobe levels {rd_e, wr_rw} for a read or a write (R1..R4)
    function automatic logic [1:0] act_stb(input bit m, input bit is_rd);
        if (!m) return is_rd ? 2'b01 : 2'b10;
        return is_rd ? 2'b11 : 2'b10;
    endfunction

    function automatic logic [7:0] exp_rd_byte(input bit addr);
        return addr ? rdata_in : status_in;
    endfunction

    task automatic go_idle(input bit m);
        cs_n = 1'b1;
        {rd_e, wr_rw} = idle_stb(m);
    endtask

    // watch 6 falling edges, collecting pulses
    task automatic watch(output int wcnt, output int wpos, output logic [7:0] wb,
                         output logic wc, output int rcnt, output int rpos,
                         input bit chk_drive, input string req);
        wcnt = 0; wpos = 0; rcnt = 0; rpos = 0; wb = '0; wc = 1'b0;
        for (int i = 1; i <= 6; i++) begin
            @(negedge clk);
            if (wr_valid) begin wcnt++; wpos = i; wb = wr_byte; wc = wr_is_cmd; end
            if (rd_ack)   begin rcnt++; rpos = i; end
            if (chk_drive) begin
                chk(bus_oe === 1'b1, req, "oe during overlap", bus_oe, 1);
                chk(bus_out === rdata_in, req, "bus_out during overlap", bus_out, rdata_in);
            end
        end
    endtask

    // kind: 0 status read, 1 data read, 2 param write, 3 command write
    task automatic run_op(input bit m, input int kind, input bit sel, input logic [7:0] d);
        int wcnt, wpos, rcnt, rpos;
        logic [7:0] wb;
        logic wc;
        bit is_rd, addr;
        string rq;
        is_rd = (kind < 2);
        addr  = kind[0];
        rq = !sel ? "R6" : (m ? "R4" : (is_rd ? "R2" : "R3"));
        @(negedge clk);
        mode_sel = m;
        go_idle(m);
        status_in = 8'($urandom);
        rdata_in  = 8'($urandom);
        @(negedge clk);
        cs_n = !sel;
        a0 = addr;
        bus_in = d;
        {rd_e, wr_rw} = act_stb(m, is_rd);
        #1;
        chk(bus_oe === (sel && is_rd), sel ? "R5" : "R6", "bus_oe while strobed", bus_oe, sel && is_rd);
        if (sel && is_rd)
            chk(bus_out === exp_rd_byte(addr), "R5", "read byte", bus_out, exp_rd_byte(addr));
        repeat (4) @(negedge clk);
        go_idle(m);
        watch(wcnt, wpos, wb, wc, rcnt, rpos, 1'b0, rq);
        chk(bus_oe === 1'b0, "R5", "oe after release", bus_oe, 0);
        if (sel && !is_rd) begin
            chk(wcnt == 1, "R7", "wr_valid count", wcnt, 1);
            chk(wpos == 3, "R7", "wr_valid edge", wpos, 3);
            chk(wb === d, rq, "wr_byte", wb, d);
            chk(wc === addr, rq, "wr_is_cmd", wc, addr);
        end else begin
            chk(wcnt == 0, rq, "spurious wr_valid", wcnt, 0);
        end
        if (sel && kind == 1) begin
            chk(rcnt == 1, "R8", "rd_ack count", rcnt, 1);
            chk(rpos == 3, "R8", "rd_ack edge", rpos, 3);
        end else begin
            chk(rcnt == 0, (sel ? "R8" : "R6"), "spurious rd_ack", rcnt, 0);
        end
    endtask

    initial begin
        #(200000 * 20);
        n_err++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

    initial begin
        int wcnt, wpos, rcnt, rpos;
        logic [7:0] wb;
        logic wc;
        void'($urandom(32'd1335));
        // R9 reset state with a read signalled on the pins
        cs_n = 1'b0; a0 = 1'b1; {rd_e, wr_rw} = 2'b01; rdata_in = 8'h5a;
        repeat (3) @(negedge clk);
        chk(bus_oe === 1'b0, "R9", "oe in reset", bus_oe, 0);
        chk({wr_valid, rd_ack, wr_is_cmd} === 3'b000, "R9", "pulses in reset",
            {wr_valid, rd_ack, wr_is_cmd}, 0);
        chk(wr_byte === 8'h00, "R9", "wr_byte in reset", wr_byte, 0);
        go_idle(1'b0);
        @(negedge clk);
        rst_n = 1'b1;

        // directed: every kind in both modes (R1)
        for (int m = 0; m < 2; m++)
            for (int k = 0; k < 4; k++)
                run_op(m[0], k, 1'b1, 8'(8'hc0 + m * 4 + k));
        // directed: deselected strobes in both modes
        run_op(1'b0, 3, 1'b0, 8'hff);
        run_op(1'b1, 2, 1'b0, 8'hee);
        run_op(1'b0, 1, 1'b0, 8'h11);

        // overlap: write strobe released while read strobe asserted (R3, R5, R7)
        @(negedge clk);
        mode_sel = 1'b0; go_idle(1'b0); rdata_in = 8'ha7; status_in = 8'h3c;
        @(negedge clk);
        cs_n = 1'b0; a0 = 1'b1; bus_in = 8'h9d; {rd_e, wr_rw} = 2'b10;
        repeat (4) @(negedge clk);
        {rd_e, wr_rw} = 2'b01;
        watch(wcnt, wpos, wb, wc, rcnt, rpos, 1'b1, "R5");
        chk(wcnt == 1 && wpos == 3, "R7", "overlap wr_valid edge", wpos, 3);
        chk(wb === 8'h9d, "R3", "overlap wr_byte", wb, 8'h9d);
        chk(wc === 1'b1, "R3", "overlap wr_is_cmd", wc, 1);
        go_idle(1'b0);
        watch(wcnt, wpos, wb, wc, rcnt, rpos, 1'b0, "R8");
        chk(rcnt == 1 && rpos == 3, "R8", "overlap rd_ack", rpos, 3);

        // R9 reset during an active read
        @(negedge clk);
        cs_n = 1'b0; a0 = 1'b0; {rd_e, wr_rw} = 2'b01;
        #1;
        chk(bus_oe === 1'b1, "R5", "oe before reset", bus_oe, 1);
        rst_n = 1'b0;
        #1;
        chk(bus_oe === 1'b0, "R9", "oe on reset", bus_oe, 0);
        @(negedge clk);
        go_idle(1'b0);
        @(negedge clk);
        rst_n = 1'b1;

        // random mix
        for (int i = 0; i < 60; i++)
            run_op(1'($urandom), int'($urandom % 4), ($urandom % 8) != 0, 8'($urandom));

        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

endmodule